// File: doc/BRIEF.md
# Shared Interrupt Source Controller

This block collects a bank of shared interrupt lines, qualifies each one according to its own configuration, and routes the result to a grid of request outputs, one per (processor target, output pin) pair. Each source can be level or edge sensitive. Its polarity bit selects high/low for level sources and rising/falling for edge sources, and a dual bit makes an edge source react to both transitions. A per-source enable (the mask) gates whether a pending source may drive any request line.

Software reaches the block through a single-cycle register port. Masks are changed by writing a source number to a dedicated set port or a dedicated clear port, so no read-modify-write is needed. A write-edge port lets software raise a latched edge event or clear one; clearing is how an edge interrupt is acknowledged. Pending and mask bitmaps, the per-source configuration, the pin map and the target map can all be read back. Raw inputs pass through a two-flop synchronizer before any level or edge qualification.

The register decoder classifies each address into one of these kinds: none, mask-set, mask-clear, write-edge, info, pending word, mask word, source config, pin map, target map. Each access is handled purely by its kind; there is no multi-cycle sequencing.

Top module: `shint_ctrl`

## Requirements
- R1: After reset every source is level sensitive and active high (config word reads 3'b001), every mask bit reads 0, every pin map and target map reads 0, and every request output is 0.
- R2: The block has NUM_GROUPS*8 sources; a read of address 0x003 returns NUM_GROUPS-1 in bits [7:0]; a source number at or above the source count written to any number-taking port changes nothing.
- R3: Writing source number n (data bits [7:0]) to address 0x000 sets only mask bit n; writing it to 0x001 clears only mask bit n.
- R4: A level source (config bit 1 = 0) is pending while its synchronized input equals its polarity bit (config bit 0), and stops being pending as soon as that no longer holds.
- R5: An edge source (config bit 1 = 1, bit 2 = 0) latches pending on a rising input when config bit 0 is 1 and on a falling input when it is 0; the opposite transition does not latch it, and the latch holds after the input returns.
- R6: With config bit 2 (dual) set, an edge source latches pending on both rising and falling inputs, whatever config bit 0 holds.
- R7: A write to address 0x002 with bit 31 = 1 latches source n (bits [7:0]) pending if it is edge sensitive; with bit 31 = 0 it clears that source's latch; an input edge detected in the same cycle as a clear wins.
- R8: Write-edge writes have no effect on a level-sensitive source: its pending state keeps following its input.
- R9: A read with rd_en returns data on rd_data after the next clock edge; word w of the pending bitmap is at 0x010+w and word w of the mask bitmap at 0x018+w, bit b being source 32w+b; bits beyond the source count and words beyond the last read as 0.
- R10: Per-source registers are written and read back at 0x100+n (bits [2:0] = {dual, edge, polarity}), 0x200+n (bit 31 = pin enable, low PIN_W bits = pin number) and 0x300+n (bit t = target t).
- R11: irq_req[t*NUM_PINS+p] is 1 exactly when some source is pending, unmasked, pin-enabled, has pin number p and has target bit t set; a pin number at or above NUM_PINS drives nothing.
- R12: An input change reaches the qualification logic after exactly two clock edges, so a level source's request changes two edges after its input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_GROUPS*8 | Raw shared interrupt lines |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 10 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 10 | Register read address |
| rd_data | output | 32 | Read data, valid after the edge that samples rd_en |
| irq_req | output | NUM_TGT*NUM_PINS | Request per target and pin, index t*NUM_PINS+p |

## Verification
The hardest case to reach from the ports is the interaction between configuration and latched edge state: a source whose polarity, dual bit and routing are rewritten between events, with a software-set latch pending while its pin number is out of range or its pin enable is off. The bench walks one edge source through rising, falling and dual configurations, acknowledging through the write-edge port after each event, then re-routes the same latched source to an invalid pin, a disabled pin and a two-target pin so the request grid is checked with an identical pending state under each routing. Write-edge traffic is also aimed at a level source to show that neither set nor clear disturbs its live pending value.

// File: rtl/shint_pkg.sv
package shint_pkg;

    localparam int REG_ADDR_W   = 10;
    localparam int CFG_POL      = 0;
    localparam int CFG_TRIG     = 1;
    localparam int CFG_DUAL     = 2;
    localparam int EDGE_SET_BIT = 31;
    localparam int PIN_EN_BIT   = 31;
    localparam logic [2:0] CFG_RESET = 3'b001;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_MASK_SET,
        SEL_MASK_CLR,
        SEL_EDGE,
        SEL_INFO,
        SEL_PEND,
        SEL_MASK_RD,
        SEL_CFG,
        SEL_PIN,
        SEL_TGT
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [REG_ADDR_W-1:0] a);
        reg_sel_e sel;
        sel = SEL_NONE;
        unique case (a[9:8])
            2'd0: begin
                if (a[7:0] == 8'h00)       sel = SEL_MASK_SET;
                else if (a[7:0] == 8'h01)  sel = SEL_MASK_CLR;
                else if (a[7:0] == 8'h02)  sel = SEL_EDGE;
                else if (a[7:0] == 8'h03)  sel = SEL_INFO;
                else if (a[7:3] == 5'b00010) sel = SEL_PEND;
                else if (a[7:3] == 5'b00011) sel = SEL_MASK_RD;
                else                       sel = SEL_NONE;
            end
            2'd1: sel = SEL_CFG;
            2'd2: sel = SEL_PIN;
            2'd3: sel = SEL_TGT;
        endcase
        return sel;
    endfunction

endpackage

// File: rtl/shint_sync.sv
module shint_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end

    logic [1:0] age;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            age <= 2'd0;
        else if (age != 2'd2)  age <= age + 2'd1;
    end

    AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd2) |-> (q == $past(d, 2))); // R12

endmodule

// File: rtl/shint_src.sv
module shint_src
    import shint_pkg::*;
#(
    parameter int PIN_W   = 3,
    parameter int NUM_TGT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               irq_sync,
    input  logic               cfg_wr,
    input  logic [2:0]         cfg_data,
    input  logic               pin_wr,
    input  logic               pin_en_data,
    input  logic [PIN_W-1:0]   pin_num_data,
    input  logic               tgt_wr,
    input  logic [NUM_TGT-1:0] tgt_data,
    input  logic               mask_set,
    input  logic               mask_clr,
    input  logic               edge_set,
    input  logic               edge_clr,
    output logic               pend,
    output logic               mask,
    output logic [2:0]         cfg,
    output logic               pin_en,
    output logic [PIN_W-1:0]   pin_num,
    output logic [NUM_TGT-1:0] tgt
);

    logic prev;
    logic edge_pend;
    logic rise, fall, edge_hit;
    logic pol, trig, dual;

    assign pol  = cfg[CFG_POL];
    assign trig = cfg[CFG_TRIG];
    assign dual = cfg[CFG_DUAL];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= irq_sync;
    end

    always_comb begin
        rise     = irq_sync & ~prev;
        fall     = ~irq_sync & prev;
        edge_hit = dual ? (rise | fall) : (pol ? rise : fall);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cfg <= CFG_RESET;
        else if (cfg_wr) cfg <= cfg_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        mask <= 1'b0;
        else if (mask_set) mask <= 1'b1;
        else if (mask_clr) mask <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    edge_pend <= 1'b0;
        else if (!trig)                edge_pend <= 1'b0;
        else if (edge_hit || edge_set) edge_pend <= 1'b1;
        else if (edge_clr)             edge_pend <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_en  <= 1'b0;
            pin_num <= '0;
        end else if (pin_wr) begin
            pin_en  <= pin_en_data;
            pin_num <= pin_num_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      tgt <= '0;
        else if (tgt_wr) tgt <= tgt_data;
    end

    assign pend = trig ? edge_pend : (irq_sync == pol);

    AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        mask_set |=> mask); // R3
    AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_clr && !mask_set) |=> !mask); // R3
    AST_EDGE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && edge_hit) |=> edge_pend); // R5
    AST_DUAL_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && dual && (rise || fall)) |=> edge_pend); // R6
    AST_EDGE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && edge_clr && !edge_hit && !edge_set) |=> !edge_pend); // R7

endmodule

// File: rtl/shint_route.sv
module shint_route #(
    parameter int NUM_SRC  = 40,
    parameter int NUM_PINS = 6,
    parameter int NUM_TGT  = 4,
    parameter int PIN_W    = 3
) (
    input  logic [NUM_SRC-1:0]          pend,
    input  logic [NUM_SRC-1:0]          mask,
    input  logic [NUM_SRC-1:0]          pin_en,
    input  logic [NUM_SRC*PIN_W-1:0]    pin_flat,
    input  logic [NUM_SRC*NUM_TGT-1:0]  tgt_flat,
    output logic [NUM_TGT*NUM_PINS-1:0] irq_req
);

    logic [NUM_SRC-1:0] live;
    assign live = pend & mask & pin_en;

    for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
        for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
            logic hit;
            always_comb begin
                hit = 1'b0;
                for (int s = 0; s < NUM_SRC; s++) begin
                    if (live[s] && tgt_flat[s*NUM_TGT+t] &&
                        (pin_flat[s*PIN_W +: PIN_W] == PIN_W'(p)))
                        hit = 1'b1;
                end
            end
            assign irq_req[t*NUM_PINS+p] = hit;
        end
    end

endmodule

// File: rtl/shint_ctrl.sv
module shint_ctrl
    import shint_pkg::*;
#(
    parameter int NUM_GROUPS = 5,
    parameter int NUM_PINS   = 6,
    parameter int NUM_TGT    = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_GROUPS*8-1:0]        irq_in,
    input  logic                           wr_en,
    input  logic [REG_ADDR_W-1:0]          wr_addr,
    input  logic [31:0]                    wr_data,
    input  logic                           rd_en,
    input  logic [REG_ADDR_W-1:0]          rd_addr,
    output logic [31:0]                    rd_data,
    output logic [NUM_TGT*NUM_PINS-1:0]    irq_req
);

    localparam int NUM_SRC   = NUM_GROUPS * 8;
    localparam int NUM_WORDS = (NUM_SRC + 31) / 32;
    localparam int PIN_W     = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

    reg_sel_e wr_sel, rd_sel;
    assign wr_sel = decode_addr(wr_addr);
    assign rd_sel = decode_addr(rd_addr);

    logic [NUM_SRC-1:0]         irq_sync;
    logic [NUM_SRC-1:0]         pend, mask, pin_en;
    logic [NUM_SRC*PIN_W-1:0]   pin_flat;
    logic [NUM_SRC*NUM_TGT-1:0] tgt_flat;
    logic [2:0]                 cfg_a [NUM_SRC];

    shint_sync #(.WIDTH(NUM_SRC)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (irq_in),
        .q     (irq_sync)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        logic num_hit, idx_hit;
        assign num_hit = (wr_data[7:0] == 8'(i));
        assign idx_hit = (wr_addr[7:0] == 8'(i));

        shint_src #(.PIN_W(PIN_W), .NUM_TGT(NUM_TGT)) src_i (
            .clk          (clk),
            .rst_n        (rst_n),
            .irq_sync     (irq_sync[i]),
            .cfg_wr       (wr_en && wr_sel == SEL_CFG && idx_hit),
            .cfg_data     (wr_data[2:0]),
            .pin_wr       (wr_en && wr_sel == SEL_PIN && idx_hit),
            .pin_en_data  (wr_data[PIN_EN_BIT]),
            .pin_num_data (wr_data[PIN_W-1:0]),
            .tgt_wr       (wr_en && wr_sel == SEL_TGT && idx_hit),
            .tgt_data     (wr_data[NUM_TGT-1:0]),
            .mask_set     (wr_en && wr_sel == SEL_MASK_SET && num_hit),
            .mask_clr     (wr_en && wr_sel == SEL_MASK_CLR && num_hit),
            .edge_set     (wr_en && wr_sel == SEL_EDGE && num_hit && wr_data[EDGE_SET_BIT]),
            .edge_clr     (wr_en && wr_sel == SEL_EDGE && num_hit && !wr_data[EDGE_SET_BIT]),
            .pend         (pend[i]),
            .mask         (mask[i]),
            .cfg          (cfg_a[i]),
            .pin_en       (pin_en[i]),
            .pin_num      (pin_flat[i*PIN_W +: PIN_W]),
            .tgt          (tgt_flat[i*NUM_TGT +: NUM_TGT])
        );
    end

    shint_route #(
        .NUM_SRC  (NUM_SRC),
        .NUM_PINS (NUM_PINS),
        .NUM_TGT  (NUM_TGT),
        .PIN_W    (PIN_W)
    ) route_i (
        .pend     (pend),
        .mask     (mask),
        .pin_en   (pin_en),
        .pin_flat (pin_flat),
        .tgt_flat (tgt_flat),
        .irq_req  (irq_req)
    );

    logic [NUM_WORDS*32-1:0] pend_pad, mask_pad;
    always_comb begin
        pend_pad = '0;
        mask_pad = '0;
        pend_pad[NUM_SRC-1:0] = pend;
        mask_pad[NUM_SRC-1:0] = mask;
    end

    logic [31:0] rd_next;
    always_comb begin
        rd_next = '0;
        case (rd_sel)
            SEL_INFO: rd_next[7:0] = 8'(NUM_GROUPS - 1);
            SEL_PEND: begin
                for (int w = 0; w < NUM_WORDS; w++)
                    if (rd_addr[2:0] == 3'(w)) rd_next = pend_pad[w*32 +: 32];
            end
            SEL_MASK_RD: begin
                for (int w = 0; w < NUM_WORDS; w++)
                    if (rd_addr[2:0] == 3'(w)) rd_next = mask_pad[w*32 +: 32];
            end
            SEL_CFG: begin
                for (int s = 0; s < NUM_SRC; s++)
                    if (rd_addr[7:0] == 8'(s)) rd_next[2:0] = cfg_a[s];
            end
            SEL_PIN: begin
                for (int s = 0; s < NUM_SRC; s++)
                    if (rd_addr[7:0] == 8'(s)) begin
                        rd_next[PIN_EN_BIT]  = pin_en[s];
                        rd_next[PIN_W-1:0]   = pin_flat[s*PIN_W +: PIN_W];
                    end
            end
            SEL_TGT: begin
                for (int s = 0; s < NUM_SRC; s++)
                    if (rd_addr[7:0] == 8'(s)) rd_next[NUM_TGT-1:0] = tgt_flat[s*NUM_TGT +: NUM_TGT];
            end
            default: rd_next = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_next;
    end

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (irq_req == '0)); // R1
    AST_REQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_req) |-> (|(pend & mask & pin_en))); // R11

endmodule

// File: tb/shint_ctrl_tb_top.sv
module shint_ctrl_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NG = 5;
    localparam int NP = 6;
    localparam int NT = 4;

    localparam logic [9:0] A_MSET = 10'h000;
    localparam logic [9:0] A_MCLR = 10'h001;
    localparam logic [9:0] A_EDGE = 10'h002;
    localparam logic [9:0] A_INFO = 10'h003;
    localparam logic [9:0] A_PEND = 10'h010;
    localparam logic [9:0] A_MASK = 10'h018;
    localparam logic [9:0] A_CFG  = 10'h100;
    localparam logic [9:0] A_PIN  = 10'h200;
    localparam logic [9:0] A_TGT  = 10'h300;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NG*8-1:0]  irq_in = '0;
    logic             wr_en = 1'b0;
    logic [9:0]       wr_addr = '0;
    logic [31:0]      wr_data = '0;
    logic             rd_en = 1'b0;
    logic [9:0]       rd_addr = '0;
    logic [31:0]      rd_data;
    logic [NT*NP-1:0] irq_req;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    shint_ctrl #(.NUM_GROUPS(NG), .NUM_PINS(NP), .NUM_TGT(NT)) dut_i (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .irq_req(irq_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 req after reset", 32'(irq_req), 32'h0);
        rd(A_CFG + 10'd0, d);  check("R1 cfg src0", d, 32'h1);
        rd(A_CFG + 10'd39, d); check("R1 cfg src39", d, 32'h1);
        rd(A_MASK, d);         check("R1 mask word0", d, 32'h0);
        rd(A_PIN + 10'd7, d);  check("R1/R10 pin map src7", d, 32'h0);
        rd(A_TGT + 10'd7, d);  check("R1/R10 tgt map src7", d, 32'h0);
        rd(A_INFO, d);         check("R2 group count field", d, 32'h4);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        wr(A_MSET, 32'd5);  rd(A_MASK, d);          check("R3 set mask 5", d, 32'h20);
        wr(A_MSET, 32'd35); rd(A_MASK + 10'd1, d);  check("R3 set mask 35", d, 32'h8);
        rd(A_MASK, d);                              check("R3 word0 untouched", d, 32'h20);
        wr(A_MCLR, 32'd5);  rd(A_MASK, d);          check("R3 clear mask 5", d, 32'h0);
        rd(A_MASK + 10'd1, d);                      check("R3 mask 35 kept", d, 32'h8);
        wr(A_MSET, 32'd45); rd(A_MASK, d);          check("R2 out of range set w0", d, 32'h0);
        rd(A_MASK + 10'd1, d);                      check("R2 out of range set w1", d, 32'h8);
        wr(A_MCLR, 32'd35);
    endtask

    task automatic t_level();
        logic [31:0] d;
        wr(A_PIN + 10'd3, 32'h8000_0002);
        wr(A_TGT + 10'd3, 32'h2);
        wr(A_MSET, 32'd3);
        @(negedge clk); irq_in[3] = 1'b1;
        @(negedge clk); check("R12 one edge not yet", 32'(irq_req), 32'h0);
        @(negedge clk); check("R12 R4 two edges level high", 32'(irq_req), 32'h100);
        rd(A_PEND, d);  check("R9 pending word0", d, 32'h8);
        irq_in[3] = 1'b0;
        settle(2);      check("R4 level released", 32'(irq_req), 32'h0);
        wr(A_CFG + 10'd3, 32'h0);
        check("R4 active low pending", 32'(irq_req), 32'h100);
        wr(A_MCLR, 32'd3);
        check("R11 masked source silent", 32'(irq_req), 32'h0);
        rd(A_PEND, d);  check("R9 pending ignores mask", d, 32'h8);
        wr(A_CFG + 10'd3, 32'h1);
    endtask

    task automatic t_edge();
        wr(A_CFG + 10'd10, 32'h3);
        wr(A_PIN + 10'd10, 32'h8000_0000);
        wr(A_TGT + 10'd10, 32'h1);
        wr(A_MSET, 32'd10);
        irq_in[10] = 1'b1; settle(4); check("R5 rising latched", 32'(irq_req), 32'h1);
        irq_in[10] = 1'b0; settle(4); check("R5 latch holds", 32'(irq_req), 32'h1);
        wr(A_EDGE, 32'd10);           check("R7 ack clears", 32'(irq_req), 32'h0);
        wr(A_CFG + 10'd10, 32'h2);
        irq_in[10] = 1'b1; settle(4); check("R5 rise ignored when falling", 32'(irq_req), 32'h0);
        irq_in[10] = 1'b0; settle(4); check("R5 falling latched", 32'(irq_req), 32'h1);
        wr(A_EDGE, 32'd10);           check("R7 ack falling", 32'(irq_req), 32'h0);
    endtask

    task automatic t_dual();
        wr(A_CFG + 10'd10, 32'h6);
        irq_in[10] = 1'b1; settle(4); check("R6 dual rise", 32'(irq_req), 32'h1);
        wr(A_EDGE, 32'd10);           check("R7 dual ack", 32'(irq_req), 32'h0);
        irq_in[10] = 1'b0; settle(4); check("R6 dual fall", 32'(irq_req), 32'h1);
        wr(A_EDGE, 32'd10);           check("R7 dual ack 2", 32'(irq_req), 32'h0);
    endtask

    task automatic t_soft();
        logic [31:0] d;
        wr(A_EDGE, 32'h8000_000A); check("R7 software set", 32'(irq_req), 32'h1);
        rd(A_PEND, d);             check("R9 soft pending bit", d, 32'h400);
        wr(A_EDGE, 32'd10);        check("R7 software clear", 32'(irq_req), 32'h0);
        wr(A_PIN + 10'd20, 32'h8000_0001);
        wr(A_TGT + 10'd20, 32'h8);
        wr(A_MSET, 32'd20);
        wr(A_EDGE, 32'h8000_0014); check("R8 set ignored on level", 32'(irq_req), 32'h0);
        rd(A_PEND, d);             check("R8 level pending unchanged", d, 32'h0);
        irq_in[20] = 1'b1; settle(3);
        check("R8 level follows input", 32'(irq_req), 32'h8_0000);
        wr(A_EDGE, 32'd20);        check("R8 clear ignored on level", 32'(irq_req), 32'h8_0000);
        irq_in[20] = 1'b0; settle(3);
        check("R4 level drops", 32'(irq_req), 32'h0);
    endtask

    task automatic t_route();
        logic [31:0] d;
        wr(A_PIN + 10'd10, 32'h8000_0007);
        wr(A_EDGE, 32'h8000_000A);  check("R11 pin out of range", 32'(irq_req), 32'h0);
        rd(A_PIN + 10'd10, d);      check("R10 pin readback", d, 32'h8000_0007);
        wr(A_PIN + 10'd10, 32'h0000_0005);
        check("R11 pin disabled", 32'(irq_req), 32'h0);
        wr(A_PIN + 10'd10, 32'h8000_0005);
        wr(A_TGT + 10'd10, 32'h5);
        check("R11 two targets pin5", 32'(irq_req), 32'h2_0020);
        rd(A_TGT + 10'd10, d);      check("R10 tgt readback", d, 32'h5);
        rd(A_CFG + 10'd10, d);      check("R10 cfg readback", d, 32'h6);
        wr(A_EDGE, 32'd10);         check("R7 clear after route", 32'(irq_req), 32'h0);
        irq_in[33] = 1'b1; settle(3);
        rd(A_PEND + 10'd1, d);      check("R9 pending word1", d, 32'h2);
        rd(A_PEND + 10'd2, d);      check("R9 word beyond last", d, 32'h0);
        irq_in[33] = 1'b0;
    endtask

    initial begin
        settle(3);
        rst_n = 1'b1;
        settle(1);
        t_reset();
        t_mask();
        t_level();
        t_edge();
        t_dual();
        t_soft();
        t_route();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule